// File: doc/BRIEF.md
# Predicated Vector Register File

This block stores thirty-two wide vector registers and a small set of element-mask registers, and commits vector results under per-lane predication. A result is split into 32-bit lanes. For each lane, the selected mask bit and a per-request mode flag decide whether the lane takes the new value, is cleared to zero, or keeps its current contents. Mask registers are loaded through a separate one-cycle write port.

Results are written on the rising clock edge. Two full-width read ports and a narrow read port are combinational. The narrow port returns the low 128 or low 256 bits of a register as a smaller alias of the same storage. Setting the mask selector to zero turns masking off, and every lane is then written.

Top module: `vec_pred_rf`

## Requirements
- R1: A synchronous reset clears every vector register and every mask register to zero. After reset, a merging write through any mask selector leaves its destination unchanged, and a zeroing write through any mask selector clears it.
- R2: With mask selector 0 and the write enable high, all 16 lanes of the destination take the new data, whatever the value of the zeroing flag.
- R3: With selector 1..7 and the zeroing flag low (merging), a lane whose mask bit is 1 takes the new data, and a lane whose mask bit is 0 keeps its previous value.
- R4: With selector 1..7 and the zeroing flag high, a lane whose mask bit is 1 takes the new data, and a lane whose mask bit is 0 becomes all zeros.
- R5: Bit i of the selected 16-bit mask governs lane i, which is data bits 32*i+31 down to 32*i. Bit 0 governs bits 31:0 and bit 15 governs bits 511:480.
- R6: A write takes effect at the rising edge while wrEn is high. A combinational read of the destination in the same cycle returns the old contents. With wrEn low, no register changes.
- R7: The two full-width read ports return the registers they address independently and in the same cycle.
- R8: The narrow port returns bits 255:0 of the addressed register when nrWide=1. When nrWide=0 it returns bits 127:0 in its low half and zeros in bits 255:128.
- R9: A mask write updates mask register mskWrIdx with mskWrData at the next edge. A vector write in the same cycle uses the old mask value.
- R10: Mask register 0 can be loaded, but it never predicates a write. Selector 0 is always unmasked, even when mask 0 is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Vector write request |
| wrDst | input | 5 | Destination register index |
| wrData | input | 512 | Result data, 16 lanes of 32 bits |
| wrMaskSel | input | 3 | Mask register selector, 0 = unmasked |
| wrZero | input | 1 | 1 = zeroing, 0 = merging |
| mskWrEn | input | 1 | Mask register write |
| mskWrIdx | input | 3 | Mask register index |
| mskWrData | input | 16 | New mask value |
| rdAddrA | input | 5 | Read port A index |
| rdDataA | output | 512 | Read port A data |
| rdAddrB | input | 5 | Read port B index |
| rdDataB | output | 512 | Read port B data |
| nrAddr | input | 5 | Narrow port index |
| nrWide | input | 1 | 1 = low 256 bits, 0 = low 128 bits |
| nrData | output | 256 | Narrow port data |

## Verification
Writes are driven with lane-tagged data, so every 32-bit lane carries its own index and a misrouted lane is visible. The mask patterns are asymmetric (A5C3, 0F0F, single low bit, single high bit) and tried under both merging and zeroing over a known nonzero preload, which separates the keep, clear and write outcomes and exposes any reversal of bit order. Unmasked writes are driven with the zeroing flag set and a nonzero mask 0, which shows whether selector 0 really bypasses the mask. Same-cycle cases, a read during a write and a mask load during a masked write, show whether the old state is used.

// File: rtl/vec_pred_rf_pkg.sv
package vec_pred_rf_pkg;
  parameter int VREGS    = 32;
  parameter int VWIDTH   = 512;
  parameter int ELEM     = 32;
  parameter int MREGS    = 8;
  parameter int NARROWLO = 128;
  parameter int NARROWHI = 256;
  localparam int LANES   = VWIDTH / ELEM;
  localparam int VIDXW   = $clog2(VREGS);
  localparam int MIDXW   = $clog2(MREGS);

  typedef struct packed {
    logic             en;
    logic [VIDXW-1:0] dst;
    logic [LANES-1:0] laneWr;
    logic [LANES-1:0] laneClr;
  } wbStrobe_t;
endpackage

// File: rtl/vec_pred_rf_ctl.sv
module vec_pred_rf_ctl
  import vec_pred_rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [VIDXW-1:0] wrDst,
  input  logic [MIDXW-1:0] wrMaskSel,
  input  logic             wrZero,
  input  logic             mskWrEn,
  input  logic [MIDXW-1:0] mskWrIdx,
  input  logic [LANES-1:0] mskWrData,
  output wbStrobe_t        strobe
);
  logic [LANES-1:0] maskMem [MREGS];
  logic [LANES-1:0] selMask;
  logic             unmasked;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < MREGS; m++) maskMem[m] <= '0;
    end else if (mskWrEn) begin
      maskMem[mskWrIdx] <= mskWrData;
    end
  end

  assign selMask  = maskMem[wrMaskSel];
  assign unmasked = (wrMaskSel == '0);

  always_comb begin
    strobe.en      = wrEn;
    strobe.dst     = wrDst;
    strobe.laneWr  = '0;
    strobe.laneClr = '0;
    if (wrEn) begin
      if (unmasked) begin
        strobe.laneWr = '1;
      end else begin
        strobe.laneWr  = selMask;
        strobe.laneClr = wrZero ? ~selMask : '0;
      end
    end
  end
endmodule

// File: rtl/vec_pred_rf_dp.sv
module vec_pred_rf_dp
  import vec_pred_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wbStrobe_t         strobe,
  input  logic [VWIDTH-1:0] wrData,
  input  logic [VIDXW-1:0]  rdAddrA,
  output logic [VWIDTH-1:0] rdDataA,
  input  logic [VIDXW-1:0]  rdAddrB,
  output logic [VWIDTH-1:0] rdDataB,
  input  logic [VIDXW-1:0]  nrAddr,
  input  logic              nrWide,
  output logic [NARROWHI-1:0] nrData
);
  logic [VWIDTH-1:0] nrFull;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [ELEM-1:0] laneMem [VREGS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < VREGS; r++) laneMem[r] <= '0;
      end else if (strobe.en && (strobe.laneWr[g] || strobe.laneClr[g])) begin
        laneMem[strobe.dst] <= strobe.laneClr[g] ? '0 : wrData[g*ELEM +: ELEM];
      end
    end

    assign rdDataA[g*ELEM +: ELEM] = laneMem[rdAddrA];
    assign rdDataB[g*ELEM +: ELEM] = laneMem[rdAddrB];
    assign nrFull[g*ELEM +: ELEM]  = laneMem[nrAddr];
  end

  logic unusedHigh;
  assign unusedHigh = ^nrFull[VWIDTH-1:NARROWHI];

  assign nrData = nrWide ? nrFull[NARROWHI-1:0]
                         : {{(NARROWHI-NARROWLO){unusedHigh & 1'b0}}, nrFull[NARROWLO-1:0]};
endmodule

// File: rtl/vec_pred_rf.sv
module vec_pred_rf
  import vec_pred_rf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [VIDXW-1:0]    wrDst,
  input  logic [VWIDTH-1:0]   wrData,
  input  logic [MIDXW-1:0]    wrMaskSel,
  input  logic                wrZero,
  input  logic                mskWrEn,
  input  logic [MIDXW-1:0]    mskWrIdx,
  input  logic [LANES-1:0]    mskWrData,
  input  logic [VIDXW-1:0]    rdAddrA,
  output logic [VWIDTH-1:0]   rdDataA,
  input  logic [VIDXW-1:0]    rdAddrB,
  output logic [VWIDTH-1:0]   rdDataB,
  input  logic [VIDXW-1:0]    nrAddr,
  input  logic                nrWide,
  output logic [NARROWHI-1:0] nrData
);
  wbStrobe_t strobe;

  vec_pred_rf_ctl uCtl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrDst(wrDst),
    .wrMaskSel(wrMaskSel), .wrZero(wrZero),
    .mskWrEn(mskWrEn), .mskWrIdx(mskWrIdx), .mskWrData(mskWrData),
    .strobe(strobe)
  );

  vec_pred_rf_dp uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .nrAddr(nrAddr), .nrWide(nrWide), .nrData(nrData)
  );
endmodule

// File: rtl/vec_pred_rf_chk.sv
module vec_pred_rf_chk
  import vec_pred_rf_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                wrEn,
  input logic [MIDXW-1:0]    wrMaskSel,
  input logic                wrZero,
  input logic [LANES-1:0]    laneWr,
  input logic [LANES-1:0]    laneClr,
  input logic [VIDXW-1:0]    rdAddrA,
  input logic [VWIDTH-1:0]   rdDataA,
  input logic [VWIDTH-1:0]   rdDataB,
  input logic [VIDXW-1:0]    nrAddr,
  input logic                nrWide,
  input logic [NARROWHI-1:0] nrData
);
  // R1: the first cycle after reset reads all zeros
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdDataA == '0 && rdDataB == '0));

  // R2 / R10: selector 0 writes every lane and clears none
  a_r2_unmasked_all: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrMaskSel == '0) |-> (laneWr == '1 && laneClr == '0));

  // R3: merging never clears a lane
  a_r3_merge_no_clear: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrZero) |-> (laneClr == '0));

  // R4: a lane is never both written and cleared
  a_r4_disjoint: assert property (@(posedge clk) disable iff (rst)
    (laneWr & laneClr) == '0);

  // R6: with no request, nothing is touched
  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (laneWr == '0 && laneClr == '0));

  // R8: the 128-bit view has a zero upper half
  a_r8_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    !nrWide |-> (nrData[NARROWHI-1:NARROWLO] == '0));

  // R8: the narrow view aliases the same storage as port A
  a_r8_alias: assert property (@(posedge clk) disable iff (rst)
    (nrAddr == rdAddrA) |-> (nrData[NARROWLO-1:0] == rdDataA[NARROWLO-1:0]));
endmodule

bind vec_pred_rf vec_pred_rf_chk uChk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrMaskSel(wrMaskSel), .wrZero(wrZero),
  .laneWr(strobe.laneWr), .laneClr(strobe.laneClr),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdDataB(rdDataB),
  .nrAddr(nrAddr), .nrWide(nrWide), .nrData(nrData)
);

// File: tb/vec_pred_rf_test.sv
`timescale 1ns/1ps
module vec_pred_rf_test;
  logic clk = 0;
  logic rst;
  logic wrEn;
  logic [4:0] wrDst;
  logic [511:0] wrData;
  logic [2:0] wrMaskSel;
  logic wrZero;
  logic mskWrEn;
  logic [2:0] mskWrIdx;
  logic [15:0] mskWrData;
  logic [4:0] rdAddrA, rdAddrB, nrAddr;
  logic [511:0] rdDataA, rdDataB;
  logic nrWide;
  logic [255:0] nrData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_pred_rf uut (.*);

  function automatic logic [511:0] pat(input logic [15:0] tag);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = {tag, 16'(i)};
    return r;
  endfunction

  function automatic logic [511:0] expWb(input logic [511:0] oldV, input logic [511:0] newV,
                                         input logic [15:0] m, input bit zero);
    logic [511:0] r;
    for (int i = 0; i < 16; i++)
      r[i*32 +: 32] = m[i] ? newV[i*32 +: 32] : (zero ? 32'h0 : oldV[i*32 +: 32]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic vwr(input logic [4:0] d, input logic [511:0] v, input logic [2:0] s, input bit z);
    wrEn = 1; wrDst = d; wrData = v; wrMaskSel = s; wrZero = z;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic mwr(input logic [2:0] k, input logic [15:0] v);
    mskWrEn = 1; mskWrIdx = k; mskWrData = v;
    @(posedge clk); #1;
    mskWrEn = 0;
  endtask

  task automatic rdA(input logic [4:0] a, output logic [511:0] v);
    rdAddrA = a; #1; v = rdDataA;
  endtask

  task automatic testReset();
    logic [511:0] v;
    bit allZero = 1;
    for (int r = 0; r < 32; r++) begin
      rdA(5'(r), v);
      if (v !== '0) allZero = 0;
    end
    chk("R1 all regs zero", {511'b0, allZero}, 512'd1);
    vwr(5'd1, pat(16'h1111), 3'd0, 0);
    vwr(5'd1, pat(16'h2222), 3'd5, 0);
    rdA(5'd1, v);
    chk("R1 reset mask merge keeps", v, pat(16'h1111));
    vwr(5'd1, pat(16'h2222), 3'd5, 1);
    rdA(5'd1, v);
    chk("R1 reset mask zeroing clears", v, '0);
  endtask

  task automatic testUnmasked();
    logic [511:0] v;
    mwr(3'd0, 16'h0001);
    vwr(5'd2, pat(16'h3333), 3'd0, 0);
    vwr(5'd2, pat(16'h4444), 3'd0, 1);
    rdA(5'd2, v);
    chk("R2 R10 unmasked with zero flag", v, pat(16'h4444));
  endtask

  task automatic testMerge();
    logic [511:0] v;
    vwr(5'd5, pat(16'hAAAA), 3'd0, 0);
    mwr(3'd3, 16'hA5C3);
    vwr(5'd5, pat(16'hBBBB), 3'd3, 0);
    rdA(5'd5, v);
    chk("R3 merge A5C3", v, expWb(pat(16'hAAAA), pat(16'hBBBB), 16'hA5C3, 0));
  endtask

  task automatic testZero();
    logic [511:0] v;
    vwr(5'd6, pat(16'hCCCC), 3'd0, 0);
    mwr(3'd7, 16'h0F0F);
    vwr(5'd6, pat(16'hDDDD), 3'd7, 1);
    rdA(5'd6, v);
    chk("R4 zeroing 0F0F", v, expWb(pat(16'hCCCC), pat(16'hDDDD), 16'h0F0F, 1));
  endtask

  task automatic testLaneOrder();
    logic [511:0] v;
    vwr(5'd7, pat(16'h5555), 3'd0, 0);
    mwr(3'd1, 16'h0001);
    vwr(5'd7, {512{1'b1}}, 3'd1, 1);
    rdA(5'd7, v);
    chk("R5 bit0 lane0", v, {480'b0, 32'hFFFFFFFF});
    vwr(5'd8, pat(16'h6666), 3'd0, 0);
    mwr(3'd2, 16'h8000);
    vwr(5'd8, {512{1'b1}}, 3'd2, 0);
    rdA(5'd8, v);
    chk("R5 bit15 lane15", v, {32'hFFFFFFFF, pat(16'h6666)[479:0]});
  endtask

  task automatic testReadDuringWrite();
    logic [511:0] v;
    vwr(5'd9, pat(16'h7777), 3'd0, 0);
    rdAddrA = 5'd9;
    wrEn = 1; wrDst = 5'd9; wrData = pat(16'h8888); wrMaskSel = 0; wrZero = 0;
    #1; v = rdDataA;
    chk("R6 same cycle read old", v, pat(16'h7777));
    @(posedge clk); #1;
    wrEn = 0;
    v = rdDataA;
    chk("R6 after edge new", v, pat(16'h8888));
    wrDst = 5'd9; wrData = pat(16'h9999);
    @(posedge clk); #1;
    chk("R6 no enable no change", rdDataA, pat(16'h8888));
  endtask

  task automatic testTwoPorts();
    rdAddrA = 5'd5; rdAddrB = 5'd9; #1;
    chk("R7 port A", rdDataA, expWb(pat(16'hAAAA), pat(16'hBBBB), 16'hA5C3, 0));
    chk("R7 port B", rdDataB, pat(16'h8888));
  endtask

  task automatic testNarrow();
    nrAddr = 5'd9; nrWide = 1; #1;
    chk("R8 wide256", {256'b0, nrData}, {256'b0, pat(16'h8888)[255:0]});
    nrWide = 0; #1;
    chk("R8 narrow128", {256'b0, nrData}, {384'b0, pat(16'h8888)[127:0]});
  endtask

  task automatic testMaskSameCycle();
    logic [511:0] v;
    vwr(5'd10, pat(16'hEEEE), 3'd0, 0);
    mwr(3'd4, 16'hFFFF);
    mskWrEn = 1; mskWrIdx = 3'd4; mskWrData = 16'h0000;
    vwr(5'd10, pat(16'hF0F0), 3'd4, 0);
    mskWrEn = 0;
    rdA(5'd10, v);
    chk("R9 same cycle uses old mask", v, pat(16'hF0F0));
    vwr(5'd10, pat(16'h0A0A), 3'd4, 0);
    rdA(5'd10, v);
    chk("R9 new mask next cycle", v, pat(16'hF0F0));
  endtask

  initial begin
    rst = 1; wrEn = 0; wrDst = 0; wrData = 0; wrMaskSel = 0; wrZero = 0;
    mskWrEn = 0; mskWrIdx = 0; mskWrData = 0;
    rdAddrA = 0; rdAddrB = 0; nrAddr = 0; nrWide = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    testReset();
    testUnmasked();
    testMerge();
    testZero();
    testLaneOrder();
    testReadDuringWrite();
    testTwoPorts();
    testNarrow();
    testMaskSameCycle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule